// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block sits in front of a small two-sector serial NOR array and decides, frame by frame, whether a data-modifying command may run. It watches SPI mode-0 frames (active-low select, clock, serial data in). It samples all of these with its own system clock, so the SPI clock must be slower than half the system clock. It keeps the write enable latch, the two block-protect bits, the status-register write-disable bit, a busy flag and a deep power-down flag. It also samples a hardware write-protect pin.

The decision is made when select returns high. The command must have a legal bit count and a prior write enable. It must also pass the block-protect rules for its type and the hardware-protect rule, and the block must be neither busy nor powered down. When all of this holds, the block raises a one-cycle accept pulse for the command type, together with the addressed sector, and sets busy. The array logic reports the end of the operation on a single done input. The status byte is offered continuously for the read path.

Top module: `flash_wprot_ctl`

## Requirements
- R1: Reset is synchronous and active low. After reset, the write enable latch, busy and power-down are 0, and the block-protect and write-disable bits equal `nv_bp` and `nv_srwd`. The status byte is {write-disable, 3'b000, block-protect[1:0], write-enable latch, busy}, so bits 6:4 always read 0.
- R2: A frame of exactly 8 clocks carrying 0x06 sets the write enable latch. One carrying 0x04 clears it. The same opcodes in a frame of any other length have no effect.
- R3: The modifying opcodes are 0x02 program, 0xD8 sector erase, 0xC7 bulk erase and 0x01 status write. Each is discarded unless the count of SPI clock rising edges in its frame is a nonzero multiple of 8. Program and sector erase also need at least 32 clocks, and status write needs at least 16.
- R4: A modifying command is discarded while the write enable latch is 0. A discarded command changes no state.
- R5: Program and sector erase are accepted when block-protect is 00, 01 or 10, and discarded when it is 11. The reported sector is address bit 15, which is the 17th data bit of the frame. The address is 24 bits, MSB first, after the opcode.
- R6: Bulk erase is accepted only when block-protect is 00.
- R7: A status write is discarded when `wp_n` is 0 and write-disable is 1. Otherwise it loads write-disable from data bit 7 and block-protect from data bits 3:2, and leaves the other status bits unchanged.
- R8: An accepted command gives exactly one one-cycle pulse on its own accept output, in the clock cycle after select is sampled high, and busy reads 1 from that cycle on.
- R9: While busy, every command is ignored. `done` while busy clears busy and the write enable latch. `done` while not busy has no effect.
- R10: A frame of exactly 8 clocks carrying 0xB9 enters power-down. While powered down, only an 8-clock 0xAB frame does anything, and it leaves power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | SPI select, active low |
| sck | input | 1 | SPI clock (mode 0, sampled) |
| mosi | input | 1 | SPI serial data in |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| done | input | 1 | Operation complete from array logic |
| nv_bp | input | 2 | Stored block-protect bits loaded at reset |
| nv_srwd | input | 1 | Stored write-disable bit loaded at reset |
| prog_ok | output | 1 | Program accepted pulse |
| serase_ok | output | 1 | Sector erase accepted pulse |
| berase_ok | output | 1 | Bulk erase accepted pulse |
| swrite_ok | output | 1 | Status write accepted pulse |
| op_sector | output | 1 | Sector of the last accepted program or sector erase |
| status | output | 8 | Status byte |
| pdown | output | 1 | Deep power-down flag |

## Verification
A wrong latch, protect level or power-down flag shows up at the ports at the next select rise. Either an accept pulse appears that should not, or one is missing. The state bits themselves also appear in the status byte in the very cycle after they change. The reference model therefore compares the status byte, the power-down flag and all four pulses on every clock. A wrong decision is then seen one cycle after the frame ends, and a wrong state update is seen at the next clock. The sector output is compared whenever a program or sector erase pulse is expected.

// File: rtl/wpc_pkg.sv
// Package: opcodes and status-byte layout shared by the write-protection
// controller. Assumes 8-bit opcodes sent MSB first.
package wpc_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_SERA = 8'h D8;
    localparam logic [7:0] OP_BERA = 8'hC7;
    localparam logic [7:0] OP_DPD  = 8'hB9;
    localparam logic [7:0] OP_RDPD = 8'hAB;

    localparam int SB_SRWD = 7;
    localparam int SB_BP_HI = 3;
    localparam int SB_BP_LO = 2;
endpackage

// File: rtl/wpc_frame_rx.sv
// Frame receiver: oversamples mode-0 SPI with clk, counts clock rising edges
// while select is low, captures the opcode, the first data byte and address
// bit 15. Assumes cs_n/sck/mosi are already synchronous to clk and sck is
// slower than clk/2. Outputs are valid in the cycle frame_end is high.
module wpc_frame_rx #(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    output logic       frame_end,
    output logic [7:0] op,
    output logic [7:0] data1,
    output logic       sec,
    output logic       mod8,
    output logic       len8,
    output logic       len16,
    output logic       len32
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             cs_q, sck_q, sck_rise;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       phase;
    logic [7:0]       sr;

    // Edge history for select and SPI clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= cs_n;
            sck_q <= sck;
        end
    end

    assign sck_rise  = !cs_n && sck && !sck_q;
    assign frame_end = cs_n && !cs_q;

    // Bit counting and field capture; cleared whenever select is high.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            cnt   <= '0;
            phase <= '0;
            sr    <= '0;
            op    <= '0;
            data1 <= '0;
            sec   <= 1'b0;
        end else if (sck_rise) begin
            sr    <= {sr[6:0], mosi};
            phase <= phase + 3'd1;
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(7))  op    <= {sr[6:0], mosi};
            if (cnt == CNT_W'(15)) data1 <= {sr[6:0], mosi};
            if (cnt == CNT_W'(16)) sec   <= mosi;
        end
    end

    assign mod8  = (phase == 3'd0) && (cnt != '0);
    assign len8  = (cnt == CNT_W'(8));
    assign len16 = (cnt >= CNT_W'(16));
    assign len32 = (cnt >= CNT_W'(32));

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !sck_rise) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/wpc_policy.sv
// Policy: combinational accept/discard decision for the frame that ends in
// this cycle. Assumes the frame fields are valid while frame_end is high.
module wpc_policy (
    input  logic       frame_end,
    input  logic [7:0] op,
    input  logic       mod8,
    input  logic       len8,
    input  logic       len16,
    input  logic       len32,
    input  logic       wel,
    input  logic       busy,
    input  logic       pdown,
    input  logic [1:0] bp,
    input  logic       srwd,
    input  logic       wp_n,
    output logic       do_wren,
    output logic       do_wrdi,
    output logic       do_dpd,
    output logic       do_rdpd,
    output logic       acc_prog,
    output logic       acc_sera,
    output logic       acc_bera,
    output logic       acc_wrsr
);
    import wpc_pkg::*;

    logic live, awake, mod_ok;

    // Gate terms common to every command.
    always_comb begin
        live   = frame_end && !busy;
        awake  = live && !pdown;
        mod_ok = awake && mod8 && wel;
    end

    // Per-opcode decision.
    always_comb begin
        do_wren  = awake && len8 && (op == OP_WREN);
        do_wrdi  = awake && len8 && (op == OP_WRDI);
        do_dpd   = awake && len8 && (op == OP_DPD);
        do_rdpd  = live && pdown && len8 && (op == OP_RDPD);
        acc_prog = mod_ok && len32 && (op == OP_PROG) && (bp != 2'b11);
        acc_sera = mod_ok && len32 && (op == OP_SERA) && (bp != 2'b11);
        acc_bera = mod_ok && (op == OP_BERA) && (bp == 2'b00);
        acc_wrsr = mod_ok && len16 && (op == OP_WRSR) && !(!wp_n && srwd);
    end
endmodule

// File: rtl/wpc_state.sv
// State: write enable latch, protect bits, busy, power-down and the
// registered accept pulses. Assumes at most one command strobe per cycle.
module wpc_state (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] nv_bp,
    input  logic       nv_srwd,
    input  logic       done,
    input  logic       do_wren,
    input  logic       do_wrdi,
    input  logic       do_dpd,
    input  logic       do_rdpd,
    input  logic       acc_prog,
    input  logic       acc_sera,
    input  logic       acc_bera,
    input  logic       acc_wrsr,
    input  logic [7:0] data1,
    input  logic       sec,
    output logic       wel,
    output logic       busy,
    output logic       pdown,
    output logic [1:0] bp,
    output logic       srwd,
    output logic [3:0] pulses,
    output logic       op_sector
);
    import wpc_pkg::*;

    logic any_acc;
    assign any_acc = acc_prog | acc_sera | acc_bera | acc_wrsr;

    // Write enable latch and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel  <= 1'b0;
            busy <= 1'b0;
        end else if (busy) begin
            if (done) begin
                busy <= 1'b0;
                wel  <= 1'b0;
            end
        end else begin
            if (any_acc) busy <= 1'b1;
            if (do_wren) wel <= 1'b1;
            else if (do_wrdi) wel <= 1'b0;
        end
    end

    // Power-down flag.
    always_ff @(posedge clk) begin
        if (!rst_n) pdown <= 1'b0;
        else if (do_dpd) pdown <= 1'b1;
        else if (do_rdpd) pdown <= 1'b0;
    end

    // Protect bits: loaded at reset, rewritten by an accepted status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp   <= nv_bp;
            srwd <= nv_srwd;
        end else if (acc_wrsr) begin
            bp   <= data1[SB_BP_HI:SB_BP_LO];
            srwd <= data1[SB_SRWD];
        end
    end

    // Accept pulses and the sector they carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulses    <= '0;
            op_sector <= 1'b0;
        end else begin
            pulses <= {acc_wrsr, acc_bera, acc_sera, acc_prog};
            if (acc_prog || acc_sera) op_sector <= sec;
        end
    end

    // R8
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulses));
    // R8
    pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulses != 4'b0) |-> busy);
    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> (!busy && !wel));
    // R10
    pd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pdown && !do_rdpd) |=> (pdown && $stable(wel)));
endmodule

// File: rtl/flash_wprot_ctl.sv
// Top: serial flash write-protection controller. Receives SPI frames,
// decides at select rise whether a modifying command runs, and keeps the
// protection state. Assumes SPI inputs synchronous to clk.
module flash_wprot_ctl #(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic       wp_n,
    input  logic       done,
    input  logic [1:0] nv_bp,
    input  logic       nv_srwd,
    output logic       prog_ok,
    output logic       serase_ok,
    output logic       berase_ok,
    output logic       swrite_ok,
    output logic       op_sector,
    output logic [7:0] status,
    output logic       pdown
);
    logic       fe, sec, mod8, len8, len16, len32;
    logic [7:0] op, data1;
    logic       wel, busy, srwd;
    logic [1:0] bp;
    logic       do_wren, do_wrdi, do_dpd, do_rdpd;
    logic       acc_prog, acc_sera, acc_bera, acc_wrsr;
    logic [3:0] pulses;

    wpc_frame_rx #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .frame_end(fe), .op(op), .data1(data1), .sec(sec),
        .mod8(mod8), .len8(len8), .len16(len16), .len32(len32)
    );

    wpc_policy u_pol (
        .frame_end(fe), .op(op), .mod8(mod8), .len8(len8), .len16(len16),
        .len32(len32), .wel(wel), .busy(busy), .pdown(pdown), .bp(bp),
        .srwd(srwd), .wp_n(wp_n), .do_wren(do_wren), .do_wrdi(do_wrdi),
        .do_dpd(do_dpd), .do_rdpd(do_rdpd), .acc_prog(acc_prog),
        .acc_sera(acc_sera), .acc_bera(acc_bera), .acc_wrsr(acc_wrsr)
    );

    wpc_state u_st (
        .clk(clk), .rst_n(rst_n), .nv_bp(nv_bp), .nv_srwd(nv_srwd),
        .done(done), .do_wren(do_wren), .do_wrdi(do_wrdi), .do_dpd(do_dpd),
        .do_rdpd(do_rdpd), .acc_prog(acc_prog), .acc_sera(acc_sera),
        .acc_bera(acc_bera), .acc_wrsr(acc_wrsr), .data1(data1), .sec(sec),
        .wel(wel), .busy(busy), .pdown(pdown), .bp(bp), .srwd(srwd),
        .pulses(pulses), .op_sector(op_sector)
    );

    assign {swrite_ok, berase_ok, serase_ok, prog_ok} = pulses;
    assign status = {srwd, 3'b000, bp, wel, busy};

    // R6
    bulk_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        berase_ok |-> ($past(status[3:2]) == 2'b00));
    // R5
    prog_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_ok || serase_ok) |-> ($past(status[3:2]) != 2'b11));
    // R7
    hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swrite_ok |-> !($past(!wp_n) && $past(status[7])));
    // R4
    need_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !$past(status[0])) |-> ($past(status[1]) && !$past(pdown)));
endmodule

// File: tb/sim_flash_wprot_ctl.sv
module sim_flash_wprot_ctl;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic wp_n = 1'b1, done = 1'b0, nv_srwd = 1'b1;
    logic [1:0] nv_bp = 2'b01;
    logic prog_ok, serase_ok, berase_ok, swrite_ok, op_sector, pdown;
    logic [7:0] status;

    int n_chk = 0, n_fail = 0;
    bit chk_en = 0;

    // reference model
    bit m_wel, m_busy, m_pd, m_srwd, m_sec;
    bit [1:0] m_bp;
    bit [3:0] m_pul;  // {wrsr, bera, sera, prog}

    flash_wprot_ctl u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .wp_n(wp_n), .done(done), .nv_bp(nv_bp), .nv_srwd(nv_srwd),
        .prog_ok(prog_ok), .serase_ok(serase_ok), .berase_ok(berase_ok),
        .swrite_ok(swrite_ok), .op_sector(op_sector), .status(status),
        .pdown(pdown)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (chk_en) begin
            chk("R1 status byte", status, {m_srwd, 3'b000, m_bp, m_wel, m_busy});
            chk("R10 power-down flag", {7'b0, pdown}, {7'b0, m_pd});
            chk("R8 accept pulses", {4'b0, swrite_ok, berase_ok, serase_ok, prog_ok},
                {4'b0, m_pul});
            if (m_pul[1:0] != 2'b00)
                chk("R5 sector", {7'b0, op_sector}, {7'b0, m_sec});
        end
    end

    task automatic frame(input logic [63:0] d, input int nb);
        bit [7:0] opc, b1;
        bit [3:0] pul;
        bit ok;
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            mosi = d[63-i];
            sck  = 1'b0;
            repeat (2) @(negedge clk);
            sck = 1'b1;
            repeat (2) @(negedge clk);
        end
        sck = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        opc = d[63:56];
        b1  = d[55:48];
        pul = 4'b0;
        ok  = (nb % 8 == 0) && (nb > 0) && m_wel;
        @(posedge clk);
        #1;
        if (!m_busy && nb >= 8) begin
            if (m_pd) begin
                if (opc == 8'hAB && nb == 8) m_pd = 0;
            end else begin
                case (opc)
                    8'h06: if (nb == 8) m_wel = 1;
                    8'h04: if (nb == 8) m_wel = 0;
                    8'hB9: if (nb == 8) m_pd = 1;
                    8'h02: if (ok && nb >= 32 && m_bp != 2'b11) pul = 4'b0001;
                    8'hD8: if (ok && nb >= 32 && m_bp != 2'b11) pul = 4'b0010;
                    8'hC7: if (ok && m_bp == 2'b00) pul = 4'b0100;
                    8'h01: if (ok && nb >= 16 && !(!wp_n && m_srwd)) begin
                        pul = 4'b1000;
                        m_srwd = b1[7];
                        m_bp = b1[3:2];
                    end
                    default: ;
                endcase
                if (pul != 0) m_busy = 1;
                if (pul[1:0] != 0) m_sec = d[47];
            end
        end
        m_pul = pul;
        @(posedge clk);
        #1;
        m_pul = 4'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_op;
        @(negedge clk) done = 1'b1;
        @(posedge clk);
        #1;
        if (m_busy) begin
            m_busy = 0;
            m_wel = 0;
        end
        @(negedge clk) done = 1'b0;
        @(negedge clk);
    endtask

    localparam logic [63:0] WREN = {8'h06, 56'h0};
    localparam logic [63:0] WRDI = {8'h04, 56'h0};

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_bp = 2'b01; m_srwd = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_en = 1;
        @(negedge clk);
        chk("R1 reset status", status, 8'h84);
        // R4: program without write enable
        frame({8'h02, 24'h008000, 8'hAA, 24'h0}, 40);
        chk("R4 no wel rejects", status, 8'h84);
        // R2
        frame(WREN, 8);
        chk("R2 wren sets", status, 8'h86);
        frame(WRDI, 8);
        chk("R2 wrdi clears", status, 8'h84);
        frame(WREN, 9);
        chk("R2 9-bit wren ignored", status, 8'h84);
        // R3 odd length, then R5/R8 good program in sector 1
        frame(WREN, 8);
        frame({8'h02, 24'h008000, 8'hAA, 24'h0}, 39);
        chk("R3 39-bit program rejected", status, 8'h86);
        frame({8'hD8, 24'h000000, 32'h0}, 24);
        chk("R3 short sector erase rejected", status, 8'h86);
        frame({8'h02, 24'h008000, 8'hAA, 24'h0}, 40);
        chk("R8 program busy", status, 8'h87);
        // R9 ignored while busy
        frame(WRDI, 8);
        chk("R9 wrdi while busy ignored", status, 8'h87);
        finish_op();
        chk("R9 done clears", status, 8'h84);
        finish_op();
        chk("R9 idle done no effect", status, 8'h84);
        // R6 bulk blocked at level 01, R5 sector erase allowed
        frame(WREN, 8);
        frame({8'hC7, 56'h0}, 8);
        chk("R6 bulk blocked at 01", status, 8'h86);
        frame({8'hD8, 24'h007FFF, 32'h0}, 32);
        chk("R5 sector erase at 01", status, 8'h87);
        finish_op();
        // R7 hardware lock
        wp_n = 1'b0;
        frame(WREN, 8);
        frame({8'h01, 8'h00, 48'h0}, 16);
        chk("R7 locked write rejected", status, 8'h86);
        wp_n = 1'b1;
        frame({8'h01, 8'hFF, 48'h0}, 16);
        chk("R7 write loads 7,3,2 only", status, 8'h8F);
        finish_op();
        // R5 level 11 blocks everything
        frame(WREN, 8);
        frame({8'h02, 24'h000000, 32'h0}, 40);
        frame({8'hD8, 24'h008000, 32'h0}, 32);
        frame({8'hC7, 56'h0}, 8);
        chk("R5 level 11 blocks", status, 8'h8E);
        frame({8'h01, 8'h00, 48'h0}, 8);
        chk("R3 8-bit status write rejected", status, 8'h8E);
        frame({8'h01, 8'h70, 48'h0}, 16);
        chk("R7 clear protect", status, 8'h03);
        finish_op();
        // R6 bulk at level 00
        frame(WREN, 8);
        frame({8'hC7, 56'h0}, 8);
        chk("R6 bulk at 00", status, 8'h03);
        finish_op();
        // R10 power-down
        frame({8'hB9, 56'h0}, 8);
        chk("R10 enter", {7'b0, pdown}, 8'h01);
        frame(WREN, 8);
        chk("R10 wren ignored", status, 8'h00);
        frame({8'hAB, 56'h0}, 16);
        chk("R10 long release ignored", {7'b0, pdown}, 8'h01);
        frame({8'hAB, 56'h0}, 8);
        chk("R10 release", {7'b0, pdown}, 8'h00);
        frame(WREN, 8);
        chk("R10 wren after release", status, 8'h02);
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule